// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block caches recent virtual-to-physical page mappings for a two-level paging scheme with 4 KiB pages. A lookup presents a 32-bit virtual address. In the same cycle, the 20-bit virtual page number is compared against every stored entry at once. On a match the block returns a 34-bit physical address and the permission byte stored with that mapping. If nothing matches, it raises a miss so that the surrounding memory management unit can start a page walk.

After a walk completes, the walk result is written through the insert port. The insert either overwrites an entry that already holds the same virtual page, or takes a fresh slot. Empty slots are used first. When every slot is full, the least recently used entry is replaced. A global flush input clears every mapping in one clock edge. Inserts whose permission byte lacks the valid flag are dropped.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is empty. Every accepted lookup misses, and `lk_ready_o` is high.
- R2: An accepted lookup whose page number (`lk_va_i[31:12]`) matches a stored entry asserts `lk_hit_o` in the same cycle. In that cycle `lk_pa_o` equals {stored 22-bit physical page, `lk_va_i[11:0]`} and `lk_perm_o` equals the stored permission byte.
- R3: An accepted lookup that matches no stored entry asserts `lk_miss_o`. `lk_hit_o` and `lk_miss_o` are never high together, and both are low when no lookup is accepted.
- R4: An insert with permission bit 0 (valid) set is written at the clock edge and can be looked up from the next cycle on.
- R5: An insert with permission bit 0 clear is ignored: no entry is written or evicted.
- R6: An insert whose page number is already stored overwrites that entry in place, so each page number is held at most once.
- R7: A new page goes to the lowest-numbered empty entry. If no entry is empty, it goes to the least recently used entry. The choice is made from the state before the clock edge.
- R8: A lookup hit and an insert each make the touched entry the most recently used. When both happen in the same cycle, the hit is applied first and the inserted entry ends up most recent.
- R9: A flush clears every entry at the clock edge, and lookups after that edge miss. During the flush cycle `lk_ready_o` is low, and `lk_hit_o` and `lk_miss_o` are low.
- R10: An insert in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_ready_o | output | 1 | Lookup accepted this cycle |
| lk_va_i | input | 32 | Virtual address to translate |
| lk_hit_o | output | 1 | Lookup matched a stored page |
| lk_miss_o | output | 1 | Lookup matched nothing |
| lk_pa_o | output | 34 | Physical address on a hit |
| lk_perm_o | output | 8 | Stored permission byte on a hit |
| ins_valid_i | input | 1 | Insert request |
| ins_vpn_i | input | 20 | Virtual page number to store |
| ins_ppn_i | input | 22 | Physical page number to store |
| ins_perm_i | input | 8 | Permission byte; bit 0 is the valid flag, bits 1 to 7 are read, write, execute, user, global, accessed and dirty |
| flush_i | input | 1 | Clear all entries |

## Verification
A lookup hit and an insert can fall in the same cycle. Both update the recency order, and the insert may even evict the entry that is being hit. The bench provokes this with a directed case: it fills the cache, hits the least recent entry and inserts a new page in the same cycle. It also runs long pseudo-random stretches in which lookups, inserts and occasional flushes overlap freely. A bench model that keeps recency as an ordered list judges every cycle's hit, miss, address and permission outputs. Because later lookups show which page was evicted, any error in the order of the two recency updates becomes visible at the ports.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  localparam int PAGE_OFF_W = 12;
  localparam int PERM_W     = 8;
  localparam int PERM_VALID = 0;  // insert is rejected when this bit is clear
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 22,
  parameter int PERM_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic [N-1:0]      lk_match_o,
  output logic [N-1:0]      ins_match_o,
  output logic [N-1:0]      valid_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [PERM_W-1:0] lk_perm_o
);
  logic              valid_q [N];
  logic [VPN_W-1:0]  vpn_q   [N];
  logic [PPN_W-1:0]  ppn_q   [N];
  logic [PERM_W-1:0] perm_q  [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      valid_q[g] <= 1'b0;
      else if (flush_i) valid_q[g] <= 1'b0;
      else if (sel)     valid_q[g] <= 1'b1;
    end

    // payload needs no reset: qualified by valid_q
    always_ff @(posedge clk_i) begin
      if (sel) begin
        vpn_q[g]  <= wr_vpn_i;
        ppn_q[g]  <= wr_ppn_i;
        perm_q[g] <= wr_perm_i;
      end
    end

    assign valid_o[g]     = valid_q[g];
    assign lk_match_o[g]  = valid_q[g] && (vpn_q[g] == lk_vpn_i);
    assign ins_match_o[g] = valid_q[g] && (vpn_q[g] == wr_vpn_i);
  end

  // AND-OR readout, relies on at most one match
  always_comb begin
    lk_ppn_o  = '0;
    lk_perm_o = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match_o[i]) begin
        lk_ppn_o  = lk_ppn_o  | ppn_q[i];
        lk_perm_o = lk_perm_o | perm_q[i];
      end
    end
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             hit_en_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic             ins_en_i,
  input  logic [IDX_W-1:0] ins_idx_i,
  input  logic [N-1:0]     valid_i,
  output logic [IDX_W-1:0] victim_o
);
  typedef logic [N-1:0][IDX_W-1:0] ages_t;

  ages_t age_q, age_mid, age_d;

  // age 0 = most recent, N-1 = least recent
  function automatic ages_t touch(input ages_t a, input logic [IDX_W-1:0] k);
    logic [IDX_W-1:0] cut;
    cut   = a[k];
    touch = a;
    for (int i = 0; i < N; i++)
      if (a[i] < cut) touch[i] = a[i] + 1'b1;
    touch[k] = '0;
  endfunction

  always_comb begin
    age_mid = hit_en_i ? touch(age_q, hit_idx_i) : age_q;
    age_d   = ins_en_i ? touch(age_mid, ins_idx_i) : age_mid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || flush_i) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else begin
      age_q <= age_d;
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] && !found) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++)
        if (age_q[i] == IDX_W'(N - 1)) victim_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 32,
  parameter int PPN_W       = 22,
  localparam int VPN_W      = VA_W - PAGE_OFF_W,
  localparam int PA_W       = PPN_W + PAGE_OFF_W,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  output logic              lk_ready_o,
  input  logic [VA_W-1:0]   lk_va_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [PERM_W-1:0] lk_perm_o,
  input  logic              ins_valid_i,
  input  logic [VPN_W-1:0]  ins_vpn_i,
  input  logic [PPN_W-1:0]  ins_ppn_i,
  input  logic [PERM_W-1:0] ins_perm_i,
  input  logic              flush_i
);
  logic [NUM_ENTRIES-1:0] lk_match, ins_match, ent_valid;
  logic [PPN_W-1:0]       lk_ppn;
  logic [PERM_W-1:0]      lk_perm;
  logic [IDX_W-1:0]       hit_idx, own_idx, victim, ins_idx;
  logic                   lk_fire, ins_ok;

  function automatic logic [IDX_W-1:0] enc(input logic [NUM_ENTRIES-1:0] v);
    enc = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (v[i]) enc = enc | IDX_W'(i);
  endfunction

  assign lk_ready_o = !flush_i;
  assign lk_fire    = lk_valid_i && !flush_i;
  assign lk_hit_o   = lk_fire && (|lk_match);
  assign lk_miss_o  = lk_fire && !(|lk_match);
  assign lk_pa_o    = {lk_ppn, lk_va_i[PAGE_OFF_W-1:0]};
  assign lk_perm_o  = lk_perm;

  assign ins_ok  = ins_valid_i && ins_perm_i[PERM_VALID] && !flush_i;
  assign hit_idx = enc(lk_match);
  assign own_idx = enc(ins_match);
  assign ins_idx = (|ins_match) ? own_idx : victim;

  xlat_cam #(
    .N(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
  ) u_cam (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .wr_en_i(ins_ok), .wr_idx_i(ins_idx),
    .wr_vpn_i(ins_vpn_i), .wr_ppn_i(ins_ppn_i), .wr_perm_i(ins_perm_i),
    .lk_vpn_i(lk_va_i[VA_W-1:PAGE_OFF_W]),
    .lk_match_o(lk_match), .ins_match_o(ins_match), .valid_o(ent_valid),
    .lk_ppn_o(lk_ppn), .lk_perm_o(lk_perm)
  );

  xlat_lru #(.N(NUM_ENTRIES)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .hit_en_i(lk_hit_o), .hit_idx_i(hit_idx),
    .ins_en_i(ins_ok), .ins_idx_i(ins_idx),
    .valid_i(ent_valid), .victim_o(victim)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int N = 16,
  parameter int PERM_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              ins_valid_i,
  input logic [PERM_W-1:0] ins_perm_i,
  input logic              lk_hit_o,
  input logic              lk_miss_o,
  input logic              lk_ready_o,
  input logic [N-1:0]      ent_valid,
  input logic [N-1:0]      lk_match
);
  p_hit_miss_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o));

  p_flush_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!lk_ready_o && !lk_hit_o && !lk_miss_o));

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (ent_valid == '0));

  p_flush_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && ins_valid_i) |=> !lk_hit_o);

  p_reject_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !ins_perm_i[0] && !flush_i) |=> $stable(ent_valid));

  p_insert_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_perm_i[0] && !flush_i) |=> (ent_valid != '0));

  p_unique_page_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
endmodule

bind xlat_cache xlat_cache_chk #(.N(NUM_ENTRIES), .PERM_W(PERM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
  .ins_valid_i(ins_valid_i), .ins_perm_i(ins_perm_i),
  .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_ready_o(lk_ready_o),
  .ent_valid(ent_valid), .lk_match(lk_match)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0, lk_ready_o;
  logic [31:0] lk_va_i = '0;
  logic        lk_hit_o, lk_miss_o;
  logic [33:0] lk_pa_o;
  logic [7:0]  lk_perm_o;
  logic        ins_valid_i = 1'b0;
  logic [19:0] ins_vpn_i = '0;
  logic [21:0] ins_ppn_i = '0;
  logic [7:0]  ins_perm_i = '0;
  logic        flush_i = 1'b0;

  int n_chk = 0, n_fail = 0;

  // reference model: contents plus recency list (index 0 = most recent)
  bit          m_valid [N];
  logic [19:0] m_vpn   [N];
  logic [21:0] m_ppn   [N];
  logic [7:0]  m_perm  [N];
  int          rec     [N];
  logic [31:0] lfsr = 32'h1badc0de;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_ready_o(lk_ready_o), .lk_va_i(lk_va_i),
    .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_pa_o(lk_pa_o), .lk_perm_o(lk_perm_o),
    .ins_valid_i(ins_valid_i), .ins_vpn_i(ins_vpn_i), .ins_ppn_i(ins_ppn_i),
    .ins_perm_i(ins_perm_i), .flush_i(flush_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0;
      rec[i] = i;
    end
  endtask

  task automatic model_touch(input int k);
    int p = 0;
    for (int i = 0; i < N; i++) if (rec[i] == k) p = i;
    for (int i = p; i > 0; i--) rec[i] = rec[i-1];
    rec[0] = k;
  endtask

  function automatic int model_find(input logic [19:0] vpn);
    int r = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == vpn) r = i;
    return r;
  endfunction

  function automatic int model_victim();
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    return rec[N-1];
  endfunction

  task automatic cyc(input bit lv, input logic [31:0] va, input bit iv,
                     input logic [19:0] vpn, input logic [21:0] ppn,
                     input logic [7:0] perm, input bit fl, input string tag);
    int hidx, vic, tgt;
    bit ehit, emiss;
    @(negedge clk);
    lk_valid_i = lv; lk_va_i = va; ins_valid_i = iv; ins_vpn_i = vpn;
    ins_ppn_i = ppn; ins_perm_i = perm; flush_i = fl;
    #1;
    hidx  = model_find(va[31:12]);
    ehit  = lv && !fl && (hidx >= 0);
    emiss = lv && !fl && (hidx < 0);
    chk(lk_ready_o == !fl, {tag, "/R9"}, "ready", 64'(lk_ready_o), 64'(!fl));
    chk(lk_hit_o == ehit, {tag, "/R2"}, "hit", 64'(lk_hit_o), 64'(ehit));
    chk(lk_miss_o == emiss, {tag, "/R3"}, "miss", 64'(lk_miss_o), 64'(emiss));
    if (ehit) begin
      chk(lk_pa_o == {m_ppn[hidx], va[11:0]}, {tag, "/R2"}, "pa",
          64'(lk_pa_o), 64'({m_ppn[hidx], va[11:0]}));
      chk(lk_perm_o == m_perm[hidx], {tag, "/R2"}, "perm",
          64'(lk_perm_o), 64'(m_perm[hidx]));
    end
    if (fl) begin
      model_clear();
    end else begin
      vic = model_victim();
      if (ehit) model_touch(hidx);
      if (iv && perm[0]) begin
        tgt = model_find(vpn);
        if (tgt < 0) tgt = vic;
        m_valid[tgt] = 1'b1; m_vpn[tgt] = vpn; m_ppn[tgt] = ppn; m_perm[tgt] = perm;
        model_touch(tgt);
      end
    end
    @(posedge clk);
  endtask

  function automatic logic [19:0] pool(input int k);
    return 20'h40000 + 20'(k * 341);
  endfunction

  task automatic step_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  task automatic probe(input logic [19:0] vpn, input string tag);
    cyc(1'b1, {vpn, 12'(vpn * 7)}, 1'b0, '0, '0, '0, 1'b0, tag);
  endtask

  task automatic probe_pool(input int cnt, input string tag);
    for (int k = 0; k < cnt; k++) probe(pool(k), tag);
  endtask

  task automatic put(input logic [19:0] vpn, input logic [21:0] ppn,
                     input logic [7:0] perm, input string tag);
    cyc(1'b0, '0, 1'b1, vpn, ppn, perm, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: empty after reset
    probe_pool(4, "R1");

    // R4 / R7: fill all slots, then read every one back
    for (int i = 0; i < N; i++)
      put(pool(i), 22'h2000 + 22'(i * 101), 8'h01 | 8'(i << 1), "R4");
    probe_pool(N + 4, "R4");

    // R5: rejected insert evicts nothing
    put(pool(20), 22'h3ffff, 8'hfe, "R5");
    probe_pool(N + 4, "R5");

    // R6: overwrite in place
    put(pool(3), 22'h155aa, 8'hc7, "R6");
    put(pool(9), 22'h0abcd, 8'h0b, "R6");
    probe_pool(N + 4, "R6");

    // R8 / R7: hit on least recent entry plus insert in same cycle
    for (int i = 0; i < N; i++) put(pool(i), 22'h100 + 22'(i), 8'hc3, "R8");
    cyc(1'b1, {pool(0), 12'h123}, 1'b1, pool(17), 22'h3a5a5, 8'hcf, 1'b0, "R8");
    put(pool(18), 22'h11111, 8'h41, "R7");
    probe_pool(N + 4, "R7");

    // R9: flush clears everything
    cyc(1'b1, {pool(2), 12'h0}, 1'b0, '0, '0, '0, 1'b1, "R9");
    probe_pool(N + 4, "R9");

    // R10: insert with flush is dropped
    put(pool(5), 22'h22222, 8'h03, "R10");
    cyc(1'b1, {pool(5), 12'h0}, 1'b1, pool(6), 22'h33333, 8'h03, 1'b1, "R10");
    probe(pool(6), "R10");
    probe(pool(5), "R10");

    // R8: pseudo-random overlap of lookups, inserts and rare flushes
    for (int t = 0; t < 4000; t++) begin
      logic [31:0] r;
      step_lfsr(); r = lfsr;
      cyc(r[0], {pool(int'(r[12:8]) % 24), r[31:20]},
          r[1], pool(int'(r[17:13]) % 24), {r[27:18], r[11:0]},
          {r[7:2] | 6'h30, 1'b1, r[19] | r[1]},
          (r[24:20] == 5'd0), "R8");
    end
    probe_pool(24, "R7");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule